// File: doc/BRIEF.md
# Fast Link Pulse Burst Encoder

This block turns a 16-bit link code word into one burst of single-cycle link pulses on a line-side output. A burst is made of 33 pulse slots at equal spacing. The odd slots carry framing clock pulses, which are always present. The even slots carry the data bits: a pulse in the slot means 1, and an empty slot means 0. A burst therefore holds between 17 and 33 pulses.

A controller places a word on `word` and raises `start` for one cycle. The encoder captures the word and raises `busy` for the length of the burst. It sends the bits least significant first, so the five selector bits leave first. It strobes `done` once the burst is over. It then waits out a minimum gap before it will accept another start. Pulse shaping, the line driver and the spacing between bursts belong to other blocks.

Top module: `flp_burst_enc`

## Requirements
- R1: After reset, `pulse`, `busy` and `done` are low.
- R2: A `start` sampled high while idle and after the gap has run out is accepted. The word is captured, and the pulse for slot 1 and `busy` go high in the next cycle.
- R3: Slot k (k = 1..33) falls at cycle offset 1 + (k-1)*SLOT_CYC, counted from the cycle in which `start` was sampled. Every odd slot (1, 3, ..., 33) carries a pulse.
- R4: Data bit n (n = 0..15) of the captured word is sent in slot 2n+2, least significant bit first, so bits 4..0 (the selector) come first. A pulse in the slot means 1 and no pulse means 0.
- R5: Each pulse lasts exactly one cycle. `pulse` is low at every cycle that is not a slot instant.
- R6: A burst carries 17 plus the number of 1 bits in the word pulses.
- R7: A `start` while `busy` is high is ignored. The burst in flight keeps the word it captured, and its timing does not change.
- R8: `done` is high for exactly one cycle, in the cycle right after the slot 33 pulse. `busy` is low from that cycle on.
- R9: A `start` in the done cycle or in any of the following GAP_CYC-1 cycles is ignored. From offset GAP_CYC after the done cycle, a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send `word` |
| word | input | 16 | Link code word, captured on an accepted start |
| pulse | output | 1 | One-cycle link pulse (framing or data) |
| busy | output | 1 | High while a burst is in progress |
| done | output | 1 | One-cycle strobe after the final framing pulse |

## Verification
A new start request can arrive in the same cycle that `done` strobes, and it can also arrive in the cycles just after. The bench raises `start` at each offset from 0 to GAP_CYC after the done cycle. In the next cycle it checks whether `busy` rose: it must stay low for offsets below GAP_CYC and rise at GAP_CYC. A start request can also land on a slot instant in the middle of a burst. The bench injects an inverted word there and checks that the pulse train still matches the original word.

// File: rtl/flp_burst_enc.sv
module flp_burst_enc #(
  parameter int SLOT_CYC = 3125,
  parameter int GAP_CYC  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] word,
  output logic        pulse,
  output logic        busy,
  output logic        done
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int GW = $clog2(GAP_CYC + 1) > 0 ? $clog2(GAP_CYC + 1) : 1;
  localparam logic [5:0] LAST_IDX = 6'd32;

  logic [CW-1:0] cnt;
  logic [5:0]    idx;
  logic [15:0]   sh;
  logic [GW-1:0] gap;

  wire       accept   = start && !busy && (gap == '0);
  wire       slot_end = (cnt == CW'(SLOT_CYC - 1));
  wire [5:0] nidx     = idx + 6'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      gap   <= '0;
      pulse <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      pulse <= 1'b0;
      done  <= 1'b0;
      if (gap != '0) gap <= gap - 1'b1;
      if (accept) begin
        busy  <= 1'b1;
        cnt   <= '0;
        idx   <= '0;
        sh    <= word;
        pulse <= 1'b1;
      end else if (busy) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
          gap  <= GW'(GAP_CYC);
        end else if (slot_end) begin
          cnt <= '0;
          idx <= nidx;
          if (nidx[0]) begin
            pulse <= sh[0];
            sh    <= sh >> 1;
          end else begin
            pulse <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r5_pulse_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> busy);
  a_r5_single_width: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && SLOT_CYC > 1) |=> !pulse);
  a_r2_first_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (pulse && $past(start)));
  a_r8_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(pulse)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  generate
    if (GAP_CYC > 0) begin : g_gap_chk
      a_r9_no_start_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    end
  endgenerate
endmodule

// File: tb/flp_burst_enc_bench.sv
module flp_burst_enc_bench;
  localparam int S = 8;
  localparam int G = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] word = '0;
  logic pulse, busy, done;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  flp_burst_enc #(.SLOT_CYC(S), .GAP_CYC(G)) u_flp_burst_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word),
    .pulse(pulse), .busy(busy), .done(done));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pulse(input logic [15:0] w, input int t);
    int i;
    if (t < 1 || ((t - 1) % S) != 0) return 1'b0;
    i = (t - 1) / S;
    if (i > 32) return 1'b0;
    if ((i % 2) == 0) return 1'b1;
    return w[(i - 1) / 2];
  endfunction

  // Starts a burst at the next negedge; optional disturbing start at offset dt.
  task automatic burst(input logic [15:0] w, input int dt);
    int pm = 0, bm = 0, dm = 0, npul = 0, first_bad = -1;
    int last = 2 + 32 * S;
    start = 1'b1; word = w;
    @(negedge clk);
    start = 1'b0;
    for (int t = 1; t <= last; t++) begin
      if (pulse !== exp_pulse(w, t)) begin pm++; if (first_bad < 0) first_bad = t; end
      if (pulse === 1'b1) npul++;
      if (busy !== (t < last)) bm++;
      if (done !== (t == last)) dm++;
      if (t == dt) begin start = 1'b1; word = ~w; end
      else start = 1'b0;
      if (t < last) @(negedge clk);
    end
    start = 1'b0;
    check(pm == 0, dt > 0 ? "R7" : "R3", "pulse train mismatches (R4 R5)", pm, 0);
    check(npul == 17 + $countones(w), "R6", "pulse count", npul, 17 + $countones(w));
    check(bm == 0, "R2", "busy window mismatches", bm, 0);
    check(dm == 0, "R8", "done timing mismatches", dm, 0);
  endtask

  task automatic settle();
    while (busy === 1'b1) @(negedge clk);
    repeat (G + 2) @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(pulse === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs in reset",
          {pulse, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs after reset",
          {pulse, busy, done}, 0);

    burst(16'h0000, 0); settle();
    burst(16'hFFFF, 0); settle();
    burst(16'h0001, 0); settle();
    burst(16'h8000, 0); settle();
    burst(16'h001F, 0); settle();
    burst(16'hA5C3, 1 + 3 * S); settle();
    burst(16'h5A3C, 5); settle();
    for (int r = 0; r < 8; r++) begin
      logic [15:0] w = 16'($urandom);
      burst(w, (r % 2) ? 1 + 32'($urandom_range(0, 31)) * S : 0);
      settle();
    end

    for (int k = 0; k <= G; k++) begin
      burst(16'h1234, 0);
      repeat (k) @(negedge clk);
      start = 1'b1; word = 16'h00FF;
      @(negedge clk);
      start = 1'b0;
      check(busy === (k >= G), "R9", $sformatf("start at gap offset %0d", k),
            int'(busy), int'(k >= G));
      settle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule